// File: doc/BRIEF.md
# Periodic interrupt request generator

This block divides the processor clock into a fixed interval and turns the end of each interval into an interrupt request. The request becomes visible as a pending flag. It is taken only at an instruction boundary, which the control unit signals with a strobe in the last state of each instruction. In that cycle the block raises a take-interrupt pulse so that the sequencer can branch to its interrupt entry states. The pending flag drops at the clock edge that ends the pulse. The entry sequencer then returns an acknowledge once it has finished the entry sequence. No second take is issued before that acknowledge arrives.

The interval counter runs freely from reset. Its schedule is absolute: requests expire at edges PERIOD, 2·PERIOD, 3·PERIOD and so on after reset is released, however late each request was taken. With the default PERIOD of 1000, a 100 MHz clock gives one request every 10 µs. Requests are not nested, prioritised or masked. The state of the processor is saved by the entry sequencer and not here.

The controller has four states. IDLE has no request. PEND has a request waiting for a boundary. WAIT means a take has been issued and the acknowledge has not yet arrived. WAIT_PEND is WAIT with a newer request already expired. The transitions are:
- expire: IDLE→PEND.
- take: PEND→WAIT.
- take_expire: PEND→WAIT_PEND, when a boundary and an expiry fall in the same cycle.
- hold: PEND→PEND, when an expiry arrives with no boundary.
- release: WAIT→IDLE.
- release_expire: WAIT→PEND.
- late_expire: WAIT→WAIT_PEND.
- release_pending: WAIT_PEND→PEND.

Top module: `periodic_irq_gen`

## Requirements
- R1: A synchronous reset clears the interval count and the pending flag, and keeps the take pulse low. After reset is released, the pending flag first rises at the PERIOD-th rising edge.
- R2: Expiries happen at edges k·PERIOD after reset release. The pending flag is high after each such edge, whatever cycle the previous request was taken in.
- R3: Without a boundary strobe, a pending request stays pending and the take pulse stays low.
- R4: The take pulse is high in the same cycle as the boundary strobe when the controller is in PEND. It is low in the following cycle.
- R5: The pending flag falls at the edge that ends the take cycle, unless an expiry happens at that same edge.
- R6: An expiry while a request is already pending does not queue a second request. After the single take, the flag stays low until the next scheduled expiry.
- R7: After a take, a boundary strobe produces no take until the acknowledge arrives. A request that expired meanwhile is shown as pending and can be taken in the cycles after the acknowledge.
- R8: An acknowledge outside WAIT and WAIT_PEND has no effect. A boundary strobe with no pending request produces no take.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Processor clock |
| rst_i | input | 1 | Synchronous reset, active high |
| instr_last_i | input | 1 | High in the last state of the current instruction |
| entry_ack_i | input | 1 | Entry sequencer has completed the interrupt entry |
| irq_pend_o | output | 1 | An interrupt request is pending |
| irq_take_o | output | 1 | One-cycle pulse: take the interrupt now |

## Verification
The take pulse is combinational on the boundary strobe. The bench therefore checks it in the same cycle, a moment after driving the strobe at the falling edge. The pending flag is registered and is checked half a cycle after the edge that updates it. This is the edge after an expiry, or the edge that ends a take cycle. The bench counts rising edges since reset release and predicts every rise of the pending flag as a multiple of PERIOD. It sweeps the take delay across the whole interval, including the case where the acknowledge lands on the same edge as the next expiry.

// File: rtl/pirq_pkg.sv
`timescale 1ns/1ps
package pirq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_PEND      = 2'd1,
        ST_WAIT      = 2'd2,
        ST_WAIT_PEND = 2'd3
    } pirq_state_e;

endpackage

// File: rtl/pirq_counter.sv
`timescale 1ns/1ps
module pirq_counter #(
    parameter int PERIOD = 1000
) (
    input  logic clk_i,
    input  logic rst_i,
    output logic tick_o
);
    localparam int CNT_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

    logic [CNT_W-1:0] cnt_q;

    assign tick_o = (cnt_q == LAST);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= '0;
        end else if (tick_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R1
    cnt_reset_chk: assert property (@(posedge clk_i) rst_i |=> cnt_q == '0);

    // R2
    cnt_range_chk: assert property (@(posedge clk_i) disable iff (rst_i) cnt_q <= LAST);

    // R2
    cnt_wrap_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        tick_o |=> cnt_q == '0);

    // R2
    cnt_step_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !tick_o |=> cnt_q == $past(cnt_q) + 1'b1);

endmodule

// File: rtl/pirq_ctrl.sv
`timescale 1ns/1ps
module pirq_ctrl
    import pirq_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic tick_i,
    input  logic bnd_i,
    input  logic ack_i,
    output logic pend_o,
    output logic take_o
);
    pirq_state_e state_q;
    pirq_state_e state_d;

    // state register
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (tick_i) state_d = ST_PEND;                        // expire
            end
            ST_PEND: begin
                if (bnd_i) state_d = tick_i ? ST_WAIT_PEND : ST_WAIT;  // take / take_expire
            end                                                        // else hold
            ST_WAIT: begin
                if (ack_i) state_d = tick_i ? ST_PEND : ST_IDLE;       // release_expire / release
                else if (tick_i) state_d = ST_WAIT_PEND;               // late_expire
            end
            ST_WAIT_PEND: begin
                if (ack_i) state_d = ST_PEND;                          // release_pending
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        pend_o = 1'b0;
        take_o = 1'b0;
        unique case (state_q)
            ST_IDLE:      ;
            ST_PEND: begin
                pend_o = 1'b1;
                take_o = bnd_i;
            end
            ST_WAIT:      ;
            ST_WAIT_PEND: pend_o = 1'b1;
            default:      ;
        endcase
    end

    // R1
    pend_reset_chk: assert property (@(posedge clk_i) rst_i |=> !pend_o);

    // R2
    expiry_sets_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        tick_i |=> pend_o);

    // R4
    take_needs_pend_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        take_o |-> pend_o);

    // R4
    take_single_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        take_o |=> !take_o);

    // R5
    pend_drop_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(pend_o) |-> ($past(take_o) || $past(rst_i)));

endmodule

// File: rtl/periodic_irq_gen.sv
`timescale 1ns/1ps
module periodic_irq_gen #(
    parameter int PERIOD = 1000
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic instr_last_i,
    input  logic entry_ack_i,
    output logic irq_pend_o,
    output logic irq_take_o
);
    logic tick;

    pirq_counter #(
        .PERIOD (PERIOD)
    ) u_counter (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .tick_o (tick)
    );

    pirq_ctrl u_ctrl (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .tick_i (tick),
        .bnd_i  (instr_last_i),
        .ack_i  (entry_ack_i),
        .pend_o (irq_pend_o),
        .take_o (irq_take_o)
    );

endmodule

// File: tb/periodic_irq_gen_tb.sv
`timescale 1ns/1ps
module periodic_irq_gen_tb;
    localparam int P = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bnd = 1'b0;
    logic ack = 1'b0;
    logic pend;
    logic take;
    int   edges = 0;
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    always #4 clk = ~clk;

    always @(posedge clk) begin
        if (rst) edges <= 0;
        else     edges <= edges + 1;
    end

    periodic_irq_gen #(.PERIOD(P)) u_dut (
        .clk_i        (clk),
        .rst_i        (rst),
        .instr_last_i (bnd),
        .entry_ack_i  (ack),
        .irq_pend_o   (pend),
        .irq_take_o   (take)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s at edge %0d: actual=%0d expected=%0d", req, edges, act, exp);
        end
    endtask

    task automatic go(input logic b, input logic a);
        @(negedge clk);
        bnd = b;
        ack = a;
        #1;
    endtask

    // idle until the next scheduled expiry, then check the rise
    task automatic wait_rise(input logic b, input logic a, input string req);
        while (((edges + 1) % P) != 0) begin
            chk(req, pend, 0);
            chk(req, take, 0);
            go(b, a);
        end
        chk(req, pend, 0);
        go(1'b0, 1'b0);
        chk(req, pend, 1);
        chk(req, edges % P, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state and first expiry
        chk("R1", pend, 0);
        chk("R1", take, 0);
        for (int k = 1; k <= P; k++) begin
            go(1'b0, 1'b0);
            chk("R1", pend, (k == P) ? 1 : 0);
        end

        // R2 R4 R5: sweep the take delay over the interval
        for (int d = 0; d <= P - 4; d++) begin
            for (int i = 0; i < d; i++) begin
                go(1'b0, 1'b0);
                chk("R3", pend, 1);
                chk("R3", take, 0);
            end
            go(1'b1, 1'b0);
            chk("R4", take, 1);
            go(1'b0, 1'b0);
            chk("R5", pend, 0);
            chk("R4", take, 0);
            go(1'b0, 1'b1);
            chk("R5", pend, 0);
            wait_rise(1'b0, 1'b0, "R2");
        end

        // R6: a whole extra interval passes while pending
        for (int i = 0; i < P; i++) begin
            chk("R6", pend, 1);
            chk("R6", take, 0);
            go(1'b0, 1'b0);
        end
        chk("R6", pend, 1);
        go(1'b1, 1'b0);
        chk("R6", take, 1);
        go(1'b0, 1'b0);
        chk("R6", pend, 0);
        go(1'b0, 1'b1);
        wait_rise(1'b0, 1'b0, "R6");

        // R7: take without acknowledge, next expiry while waiting
        go(1'b1, 1'b0);
        chk("R7", take, 1);
        go(1'b0, 1'b0);
        chk("R7", pend, 0);
        wait_rise(1'b0, 1'b0, "R7");
        go(1'b1, 1'b0);
        chk("R7", take, 0);
        chk("R7", pend, 1);
        go(1'b0, 1'b1);
        chk("R7", take, 0);
        go(1'b0, 1'b0);
        chk("R7", pend, 1);
        go(1'b1, 1'b0);
        chk("R7", take, 1);
        go(1'b0, 1'b0);
        chk("R7", pend, 0);
        go(1'b0, 1'b1);

        // R8: boundary and acknowledge in IDLE, acknowledge in PEND
        wait_rise(1'b1, 1'b1, "R8");
        go(1'b0, 1'b1);
        chk("R8", pend, 1);
        go(1'b0, 1'b0);
        chk("R8", pend, 1);
        go(1'b1, 1'b0);
        chk("R8", take, 1);
        go(1'b0, 1'b0);
        chk("R8", pend, 0);
        go(1'b0, 1'b1);
        wait_rise(1'b0, 1'b0, "R2");

        // R1: reset while pending restarts the schedule
        @(negedge clk);
        rst = 1'b1;
        go(1'b0, 1'b0);
        chk("R1", pend, 0);
        chk("R1", take, 0);
        go(1'b0, 1'b0);
        @(negedge clk);
        rst = 1'b0;
        #1;
        for (int k = 1; k <= P; k++) begin
            go(1'b0, 1'b0);
            chk("R1", pend, (k == P) ? 1 : 0);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule